// File: doc/BRIEF.md
# Controller Frame Start Sequencer

This block sits on the controller side of a serial bus controller. It decides when the bus engine may begin emitting a frame. A frame is described by control words held in a command FIFO, and the data to send is held in a transmit FIFO. Software can open a frame in two ways. It can pulse a trigger strobe. It can also write a control word while the command FIFO is empty. While a frame description is still incomplete, the block raises a request flag that asks for another control word. When the bus engine may begin, the block sends it a one-cycle start pulse.

Two start policies are offered. In the immediate policy (`preload_mode` = 0), the frame starts as soon as the command FIFO holds a word. In the preload policy (`preload_mode` = 1), the start is held back until the command FIFO holds the whole frame description, or has filled up. When the frame carries data (`tx_needed` = 1), the transmit FIFO must also hold at least `TX_PRELOAD` bytes. A flush strobe for the command FIFO cancels any frame that has not yet started. Both outputs are registered. Each reacts in the cycle after the inputs that cause it.

The state machine has five states:
- IDLE: no frame is open.
- FETCH: words are requested and the frame has not started.
- HOLD: the frame description is complete and the frame has not started.
- RUN_FETCH: the frame has started and more words are requested.
- RUN: the frame has started and its description is complete.

Its transitions are:
- open: IDLE to FETCH, or to HOLD when the first word carries the end tag.
- close: FETCH to HOLD, or RUN_FETCH to RUN.
- launch: FETCH or HOLD to a running state.
- cancel: a flush moves FETCH or HOLD to IDLE, and RUN_FETCH to RUN.
- finish: `frame_done` moves RUN or RUN_FETCH to IDLE.

Top module: `frame_start_seq`

## Requirements
- R1: While reset is held and after its release, `cw_req` and `frame_start` are 0.
- R2: A `sw_trigger` pulse in IDLE sets `cw_req` to 1 in the next cycle, with no start pulse.
- R3: A `cw_wr` while IDLE and `cf_empty` = 1 opens a frame. If `cw_last` = 0, `cw_req` goes to 1 next cycle. If `cw_last` = 1, `cw_req` stays 0.
- R4: `cw_req` returns to 0 in the cycle after a word is written with `cw_wr` = 1 and `cw_last` = 1.
- R5: With `preload_mode` = 0, an open frame that has not started issues `frame_start` in the cycle after `cf_empty` is seen at 0.
- R6: With `preload_mode` = 1, a word present in the command FIFO does not start the frame. The start follows the end-tagged word once either `tx_needed` = 0 or `tx_level` >= `TX_PRELOAD`.
- R7: With `preload_mode` = 1, `cf_level` reaching `CF_DEPTH` before the end tag starts the frame, and `cw_req` stays 1.
- R8: `frame_start` lasts one cycle. It does not recur until `frame_done` is seen, and `sw_trigger` is ignored while a frame runs.
- R9: A `cf_flush` pulse sets `cw_req` to 0 in the next cycle. A frame that has not started returns to IDLE with no start pulse, even if a start condition holds in that cycle. A running frame keeps waiting for `frame_done`.
- R10: `cf_flush` takes priority over `sw_trigger` and `cw_wr` in the same cycle, and neither of those opens a frame.
- R11: A `cw_wr` in IDLE while `cf_empty` = 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_trigger | input | 1 | Software trigger strobe |
| cw_wr | input | 1 | Control-word write strobe |
| cw_last | input | 1 | Written word carries the end-of-message tag |
| cf_empty | input | 1 | Command FIFO empty |
| cf_level | input | $clog2(CF_DEPTH+1) | Command FIFO fill level |
| preload_mode | input | 1 | 0 = immediate start, 1 = preload before start |
| tx_needed | input | 1 | Frame format carries transmit data |
| tx_level | input | $clog2(TX_DEPTH+1) | Transmit FIFO fill level |
| cf_flush | input | 1 | Command FIFO flush strobe |
| frame_done | input | 1 | Bus engine reports frame complete |
| cw_req | output | 1 | Next control word needed |
| frame_start | output | 1 | One-cycle start pulse to the bus engine |

## Verification
A flush can arrive in the same cycle as a start condition. The bench provokes this by pulsing `cf_flush` while the FIFO shows a word present for a frame that has not started. It then expects no start pulse, `cw_req` at 0, and a block that stays idle afterwards. It also sends a flush together with a trigger, and together with a write into an empty FIFO. In both cases it expects that no frame opens.

// File: rtl/fss_pkg.sv
package fss_pkg;
    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_FETCH     = 3'd1,
        S_HOLD      = 3'd2,
        S_RUN_FETCH = 3'd3,
        S_RUN       = 3'd4
    } fss_state_e;

    function automatic logic is_running(input fss_state_e s);
        return (s == S_RUN) || (s == S_RUN_FETCH);
    endfunction

    function automatic logic is_fetching(input fss_state_e s);
        return (s == S_FETCH) || (s == S_RUN_FETCH);
    endfunction
endpackage

// File: rtl/fss_ready.sv
module fss_ready #(
    parameter int CF_DEPTH   = 8,
    parameter int TX_DEPTH   = 16,
    parameter int TX_PRELOAD = 4,
    localparam int CFL_W = $clog2(CF_DEPTH + 1),
    localparam int TXL_W = $clog2(TX_DEPTH + 1)
) (
    input  logic             preload_mode,
    input  logic             cf_empty,
    input  logic [CFL_W-1:0] cf_level,
    input  logic             tx_needed,
    input  logic [TXL_W-1:0] tx_level,
    output logic             go_open,
    output logic             go_closed
);
    localparam logic [CFL_W-1:0] CF_FULL_LVL = CFL_W'(CF_DEPTH);
    localparam logic [TXL_W-1:0] TX_PRE_LVL  = TXL_W'(TX_PRELOAD);

    logic cf_full;
    logic tx_ok;

    always_comb begin
        cf_full = (cf_level >= CF_FULL_LVL);
        tx_ok   = !tx_needed || (tx_level >= TX_PRE_LVL);
        if (preload_mode) begin
            go_open   = cf_full;
            go_closed = tx_ok;
        end else begin
            go_open   = !cf_empty;
            go_closed = !cf_empty;
        end
    end
endmodule

// File: rtl/fss_ctrl.sv
module fss_ctrl
    import fss_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_trigger,
    input  logic cw_wr,
    input  logic cw_last,
    input  logic cf_empty,
    input  logic cf_flush,
    input  logic frame_done,
    input  logic go_open,
    input  logic go_closed,
    output logic cw_req,
    output logic frame_start
);
    fss_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: begin
                if (cf_flush)                st_d = S_IDLE;
                else if (cw_wr && cf_empty)  st_d = cw_last ? S_HOLD : S_FETCH;
                else if (sw_trigger)         st_d = S_FETCH;
            end
            S_FETCH: begin
                if (cf_flush)                st_d = S_IDLE;
                else if (cw_wr && cw_last)   st_d = go_closed ? S_RUN : S_HOLD;
                else if (go_open)            st_d = S_RUN_FETCH;
            end
            S_HOLD: begin
                if (cf_flush)                st_d = S_IDLE;
                else if (go_closed)          st_d = S_RUN;
            end
            S_RUN_FETCH: begin
                if (frame_done)              st_d = S_IDLE;
                else if (cf_flush)           st_d = S_RUN;
                else if (cw_wr && cw_last)   st_d = S_RUN;
            end
            S_RUN: begin
                if (frame_done)              st_d = S_IDLE;
            end
            default:                         st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cw_req      <= 1'b0;
            frame_start <= 1'b0;
        end else begin
            cw_req      <= is_fetching(st_d);
            frame_start <= is_running(st_d) && !is_running(st_q);
        end
    end

    logic chk_busy;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           chk_busy <= 1'b0;
        else if (frame_done)  chk_busy <= 1'b0;
        else if (frame_start) chk_busy <= 1'b1;
    end

    // R8
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !chk_busy);

    // R9
    flush_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cf_flush |=> !cw_req);

    // R2
    trigger_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_IDLE && sw_trigger && !cf_flush && !cw_wr) |=> (cw_req && !frame_start));

    // R6
    preload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_HOLD && !go_closed && !cf_flush) |=> !frame_start);

    // R4
    end_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_req && cw_wr && cw_last) |=> !cw_req);
endmodule

// File: rtl/frame_start_seq.sv
module frame_start_seq #(
    parameter int CF_DEPTH   = 8,
    parameter int TX_DEPTH   = 16,
    parameter int TX_PRELOAD = 4,
    localparam int CFL_W = $clog2(CF_DEPTH + 1),
    localparam int TXL_W = $clog2(TX_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_trigger,
    input  logic             cw_wr,
    input  logic             cw_last,
    input  logic             cf_empty,
    input  logic [CFL_W-1:0] cf_level,
    input  logic             preload_mode,
    input  logic             tx_needed,
    input  logic [TXL_W-1:0] tx_level,
    input  logic             cf_flush,
    input  logic             frame_done,
    output logic             cw_req,
    output logic             frame_start
);
    logic go_open;
    logic go_closed;

    fss_ready #(
        .CF_DEPTH  (CF_DEPTH),
        .TX_DEPTH  (TX_DEPTH),
        .TX_PRELOAD(TX_PRELOAD)
    ) u_ready (
        .preload_mode(preload_mode),
        .cf_empty    (cf_empty),
        .cf_level    (cf_level),
        .tx_needed   (tx_needed),
        .tx_level    (tx_level),
        .go_open     (go_open),
        .go_closed   (go_closed)
    );

    fss_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_trigger (sw_trigger),
        .cw_wr      (cw_wr),
        .cw_last    (cw_last),
        .cf_empty   (cf_empty),
        .cf_flush   (cf_flush),
        .frame_done (frame_done),
        .go_open    (go_open),
        .go_closed  (go_closed),
        .cw_req     (cw_req),
        .frame_start(frame_start)
    );
endmodule

// File: tb/frame_start_seq_tb.sv
module frame_start_seq_tb;
    localparam int CF_DEPTH   = 8;
    localparam int TX_DEPTH   = 16;
    localparam int TX_PRELOAD = 4;
    localparam int CFL_W = $clog2(CF_DEPTH + 1);
    localparam int TXL_W = $clog2(TX_DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_trigger = 1'b0, cw_wr = 1'b0, cw_last = 1'b0, cf_empty = 1'b1;
    logic [CFL_W-1:0] cf_level = '0;
    logic preload_mode = 1'b0, tx_needed = 1'b0;
    logic [TXL_W-1:0] tx_level = '0;
    logic cf_flush = 1'b0, frame_done = 1'b0;
    logic cw_req, frame_start;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    typedef struct {
        logic  req;
        logic  st;
        string tag;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    frame_start_seq #(
        .CF_DEPTH  (CF_DEPTH),
        .TX_DEPTH  (TX_DEPTH),
        .TX_PRELOAD(TX_PRELOAD)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .sw_trigger(sw_trigger), .cw_wr(cw_wr),
        .cw_last(cw_last), .cf_empty(cf_empty), .cf_level(cf_level),
        .preload_mode(preload_mode), .tx_needed(tx_needed), .tx_level(tx_level),
        .cf_flush(cf_flush), .frame_done(frame_done),
        .cw_req(cw_req), .frame_start(frame_start)
    );

    task automatic cmp(input logic er, input logic es, input string tag);
        checks++;
        if (cw_req !== er || frame_start !== es) begin
            errors++;
            $display("FAIL %s: cw_req/frame_start actual %b/%b expected %b/%b",
                     tag, cw_req, frame_start, er, es);
        end
    endtask

    // monitor: pops one expectation after each edge
    initial forever begin
        @(posedge clk);
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            cmp(e.req, e.st, e.tag);
        end
    end

    // driver: inputs already set, push expectation, advance one cycle, clear strobes
    task automatic cyc(input logic er, input logic es, input string tag);
        exp_t e;
        e.req = er; e.st = es; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        sw_trigger = 1'b0; cw_wr = 1'b0; cw_last = 1'b0;
        cf_flush = 1'b0; frame_done = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp(1'b0, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        cmp(1'b0, 1'b0, "R1 after reset");

        // immediate mode, trigger start
        cyc(0, 0, "R1 idle");
        sw_trigger = 1; cyc(1, 0, "R2 trigger");
        cw_wr = 1;      cyc(1, 0, "R3 word not end");
        cf_empty = 0;   cyc(1, 1, "R5 word present");
        cyc(1, 0, "R8 pulse one cycle");
        sw_trigger = 1; cyc(1, 0, "R8 trigger while running");
        cw_wr = 1; cw_last = 1; cyc(0, 0, "R4 end tag");
        cyc(0, 0, "R8 no restart");
        frame_done = 1; cf_empty = 1; cyc(0, 0, "R8 done");

        // immediate mode, end-tagged first word
        cw_wr = 1; cw_last = 1; cyc(0, 0, "R3 end-tagged first word");
        cf_empty = 0; cyc(0, 1, "R5 start from hold");
        cyc(0, 0, "R8 pulse one cycle");
        frame_done = 1; cf_empty = 1; cyc(0, 0, "R8 done");

        // flush against start condition
        cw_wr = 1; cyc(1, 0, "R3 direct write");
        cf_flush = 1; cf_empty = 0; cyc(0, 0, "R9 flush beats start");
        cyc(0, 0, "R9 stays idle");
        cw_wr = 1; cyc(0, 0, "R11 write into nonempty ignored");
        cyc(0, 0, "R11 still idle");
        cf_empty = 1;

        // preload mode, data needed
        preload_mode = 1; tx_needed = 1; tx_level = '0;
        sw_trigger = 1; cyc(1, 0, "R2 trigger");
        cw_wr = 1; cyc(1, 0, "R6 word written");
        cf_empty = 0; cf_level = CFL_W'(1); cyc(1, 0, "R6 no start on present word");
        cw_wr = 1; cw_last = 1; cyc(0, 0, "R4 end tag drops req");
        tx_level = TXL_W'(TX_PRELOAD - 1); cyc(0, 0, "R6 tx short");
        tx_level = TXL_W'(TX_PRELOAD); cyc(0, 1, "R6 preload met");
        cyc(0, 0, "R8 pulse one cycle");
        frame_done = 1; cf_empty = 1; cf_level = '0; tx_level = '0; cyc(0, 0, "R8 done");

        // preload mode, C-FIFO full
        sw_trigger = 1; cyc(1, 0, "R2 trigger");
        cf_empty = 0; cf_level = CFL_W'(CF_DEPTH); cyc(1, 1, "R7 full starts");
        cyc(1, 0, "R7 req stays");
        cf_flush = 1; cyc(0, 0, "R9 flush while running");
        sw_trigger = 1; cyc(0, 0, "R8 trigger ignored");
        frame_done = 1; cf_empty = 1; cf_level = '0; cyc(0, 0, "R8 done");
        sw_trigger = 1; cyc(1, 0, "R8 new frame after done");
        cf_flush = 1; cyc(0, 0, "R9 flush in fetch");

        // preload mode, no data needed
        tx_needed = 0;
        cw_wr = 1; cw_last = 1; cyc(0, 0, "R3 end-tagged");
        cyc(0, 1, "R6 no data needed");
        frame_done = 1; cyc(0, 0, "R8 done");

        // same-cycle priorities
        cf_flush = 1; sw_trigger = 1; cyc(0, 0, "R10 flush with trigger");
        cyc(0, 0, "R10 idle");
        cf_flush = 1; cw_wr = 1; cyc(0, 0, "R10 flush with write");
        cyc(0, 0, "R10 idle");

        @(negedge clk);
        @(negedge clk);
        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule